// File: doc/BRIEF.md
# Two-Wire Memory Slave Protocol Engine

This block is the serial front end of a small memory slave on a two-wire bus. A fast system clock samples the bus clock and data lines through synchronizers. The engine recognises bus Start and Stop conditions, including a Start that arrives in the middle of a transfer. It counts bits and bytes and answers each byte it accepts with an acknowledge. For reads it shifts stored bytes out, most significant bit first. The data line is modelled as an open-drain pull-down enable, so the engine can only pull the line low or let it go.

The engine keeps an 11-bit address pointer. The upper three bits come from the selection field of the control byte and the lower eight from the word-address byte. Writes leave the engine as single-cycle byte strobes toward an external page buffer. Reads fetch from a 2048-byte array through an address output and a data input, and the data input must follow the address output combinationally. A busy input from the write-commit logic stops all acknowledges. A master can therefore poll with a control byte until the slave answers again.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling data line while the synchronized clock is high (Start) begins reception of a control byte from any state. A rising data line while the clock is high (Stop) returns the engine to idle with the line released. Bytes clocked after a Stop and before a new Start get no acknowledge.
- R2: A control byte whose bits 7:4 equal 1010b is acknowledged. Any other code gets no acknowledge, and every further byte until the next Start is ignored.
- R3: The acknowledge pulls the line low from the falling clock edge after the eighth bit, through the whole high phase of the ninth pulse. The line is released after the ninth falling edge. The engine never drives the line high.
- R4: While busy_i is high at the decision point of a byte (the eighth falling edge), that byte is not acknowledged and causes no write, even if it is a matching control byte. The engine acknowledges again once busy_i is low.
- R5: Control-byte bits 3:1 load pointer bits 10:8. The byte after a write control byte (bit 0 = 0) loads pointer bits 7:0.
- R6: Each acknowledged data byte of a write produces exactly one single-cycle wr_en_o, with wr_addr_o equal to the pointer and wr_data_o equal to the byte. The pointer then advances only in its low four bits, wrapping inside the 16-byte page.
- R7: A repeated Start after the word-address acknowledge ends the write with no write strobe. The pointer keeps the newly loaded value.
- R8: In a read (control bit 0 = 1), the byte at the pointer is sent most significant bit first, and the line changes only after a falling clock edge. The pointer then advances by one across all 11 bits, wrapping from 7FFh to 000h.
- R9: After an access to address n, a current-address read whose selection bits equal bits 10:8 of n+1 returns the byte at n+1.
- R10: A master acknowledge (line low on the ninth pulse of a read byte) makes the engine send the next byte. A master non-acknowledge makes the engine release the line and keep it released until the next Start or Stop.
- R11: After reset, sda_oe and wr_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| busy_i | input | 1 | Internal write cycle in progress; suppresses acknowledges |
| wr_en_o | output | 1 | Single-cycle byte write strobe |
| wr_addr_o | output | 11 | Address of the byte being written |
| wr_data_o | output | 8 | Byte being written |
| rd_addr_o | output | 11 | Read address (current pointer) |
| rd_data_i | input | 8 | Array byte at rd_addr_o |

## Verification
The checker follows several rules on every cycle. A Start or Stop always leaves the line released. The pull-down enable only changes while the synchronized clock is low. No pull-down starts in a receive phase right after busy_i was high. Every write strobe is a single cycle and comes together with its acknowledge. The bench scenarios are needed for behaviour that depends on byte content and sequence. These cover the control-code match, how the pointer is assembled and how it wraps within a page or across the whole array, current-address and random reads, and the release that follows a master non-acknowledge.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTRL,
      ST_WADDR,
      ST_WDATA,
      ST_TX,
      ST_HOLD
   } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic prv
);
   localparam int DEPTH = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("twi_line_sync: STAGES must be at least 2");
   end

   logic [DEPTH-1:0] pipe;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[0] <= RST_VAL;
            else        pipe[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[i] <= RST_VAL;
            else        pipe[i] <= pipe[i-1];
      end
   end

   assign lvl = pipe[STAGES-1];
   assign prv = pipe[STAGES];
endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det (
   input  logic scl_lvl,
   input  logic scl_prv,
   input  logic sda_lvl,
   input  logic sda_prv,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);
   logic scl_steady_hi;

   assign scl_steady_hi = scl_lvl & scl_prv;
   assign start_det     = scl_steady_hi & sda_prv & ~sda_lvl;
   assign stop_det      = scl_steady_hi & ~sda_prv & sda_lvl;
   assign scl_rise      = scl_lvl & ~scl_prv;
   assign scl_fall      = ~scl_lvl & scl_prv;
endmodule

// File: rtl/twi_addr_ptr.sv
module twi_addr_ptr #(
   parameter int ADDR_W = 11,
   parameter int LO_W   = 8,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hi,
   input  logic [ADDR_W-LO_W-1:0] hi_val,
   input  logic              ld_lo,
   input  logic [LO_W-1:0]   lo_val,
   input  logic              inc_seq,
   input  logic              inc_page,
   output logic [ADDR_W-1:0] ptr
);
   localparam int HI_W = ADDR_W - LO_W;

   if (HI_W < 1 || HI_W > 3) begin : g_bad_hi
      $error("twi_addr_ptr: ADDR_W-LO_W must be 1..3");
   end
   if (PAGE_W < 1 || PAGE_W > LO_W) begin : g_bad_page
      $error("twi_addr_ptr: PAGE_W must be 1..LO_W");
   end

   logic [ADDR_W-1:0] page_next;
   logic [PAGE_W-1:0] page_low;

   assign page_low  = ptr[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};
   assign page_next = {ptr[ADDR_W-1:PAGE_W], page_low};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (ld_hi) begin
         ptr[ADDR_W-1:LO_W] <= hi_val;
      end else if (ld_lo) begin
         ptr[LO_W-1:0] <= lo_val;
      end else if (inc_seq) begin
         ptr <= ptr + {{(ADDR_W-1){1'b0}}, 1'b1};
      end else if (inc_page) begin
         ptr <= page_next;
      end
   end
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
   import twi_mem_pkg::*;
#(
   parameter int         ADDR_W      = 11,
   parameter int         PAGE_W      = 4,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_CODE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              busy_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [BYTE_W-1:0] rd_data_i
);
   localparam int          HI_W    = ADDR_W - BYTE_W;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

   // bus line sampling
   logic scl_lvl, scl_prv, sda_lvl, sda_prv;
   logic start_det, stop_det, scl_rise, scl_fall;

   twi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .lvl(scl_lvl), .prv(scl_prv)
   );
   twi_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .lvl(sda_lvl), .prv(sda_prv)
   );

   twi_cond_det u_cond (
      .scl_lvl(scl_lvl), .scl_prv(scl_prv),
      .sda_lvl(sda_lvl), .sda_prv(sda_prv),
      .start_det(start_det), .stop_det(stop_det),
      .scl_rise(scl_rise), .scl_fall(scl_fall)
   );

   // protocol state
   twi_state_e        state;
   logic [CNT_W-1:0]  bcnt;
   logic [BYTE_W-1:0] shreg;
   logic              pull;
   logic              rw_rd;
   logic              mack;
   logic [ADDR_W-1:0] ptr;
   logic              in_tx;
   logic              in_rx;
   logic              no_cond;
   logic              byte_ok;
   logic              decide;
   logic              ack_end;
   logic              tx_load;

   assign in_tx   = (state == ST_TX);
   assign in_rx   = (state == ST_CTRL) || (state == ST_WADDR) || (state == ST_WDATA);
   assign no_cond = ~start_det & ~stop_det;
   assign byte_ok = ~busy_i &
                    ((state != ST_CTRL) || (shreg[BYTE_W-1:BYTE_W-4] == DEV_CODE));
   assign decide  = no_cond & in_rx & scl_fall & (bcnt == CNT_LAST);
   assign ack_end = no_cond & in_rx & scl_fall & (bcnt == CNT_ACK);
   assign tx_load = (ack_end & (state == ST_CTRL) & rw_rd) |
                    (no_cond & in_tx & scl_fall & (bcnt == CNT_ACK) & mack);

   twi_addr_ptr #(.ADDR_W(ADDR_W), .LO_W(BYTE_W), .PAGE_W(PAGE_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .ld_hi(decide & byte_ok & (state == ST_CTRL)),
      .hi_val(shreg[HI_W:1]),
      .ld_lo(decide & byte_ok & (state == ST_WADDR)),
      .lo_val(shreg),
      .inc_seq(tx_load),
      .inc_page(decide & byte_ok & (state == ST_WDATA)),
      .ptr(ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bcnt      <= '0;
         shreg     <= '0;
         pull      <= 1'b0;
         rw_rd     <= 1'b0;
         mack      <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (start_det) begin
            state <= ST_CTRL;
            bcnt  <= '0;
            pull  <= 1'b0;
         end else if (stop_det) begin
            state <= ST_IDLE;
            bcnt  <= '0;
            pull  <= 1'b0;
         end else begin
            unique case (state)
               ST_CTRL, ST_WADDR, ST_WDATA: begin
                  if (scl_rise && bcnt < CNT_LAST) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                     bcnt  <= bcnt + 1'b1;
                  end else if (decide) begin
                     if (byte_ok) begin
                        pull <= 1'b1;
                        bcnt <= CNT_ACK;
                        if (state == ST_CTRL) rw_rd <= shreg[0];
                        if (state == ST_WDATA) begin
                           wr_en_o   <= 1'b1;
                           wr_addr_o <= ptr;
                           wr_data_o <= shreg;
                        end
                     end else begin
                        state <= ST_IDLE;
                        bcnt  <= '0;
                     end
                  end else if (ack_end) begin
                     pull <= 1'b0;
                     bcnt <= '0;
                     if (state == ST_CTRL) begin
                        if (rw_rd) begin
                           state <= ST_TX;
                           shreg <= rd_data_i;
                           pull  <= ~rd_data_i[BYTE_W-1];
                        end else begin
                           state <= ST_WADDR;
                        end
                     end else begin
                        state <= ST_WDATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     if (bcnt < CNT_LAST) begin
                        bcnt <= bcnt + 1'b1;
                     end else if (bcnt == CNT_LAST) begin
                        mack <= ~sda_lvl;
                        bcnt <= CNT_ACK;
                     end
                  end else if (scl_fall) begin
                     if (bcnt != '0 && bcnt < CNT_LAST) begin
                        shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        pull  <= ~shreg[BYTE_W-2];
                     end else if (bcnt == CNT_LAST) begin
                        pull <= 1'b0;
                     end else if (bcnt == CNT_ACK) begin
                        bcnt <= '0;
                        if (mack) begin
                           shreg <= rd_data_i;
                           pull  <= ~rd_data_i[BYTE_W-1];
                        end else begin
                           state <= ST_HOLD;
                           pull  <= 1'b0;
                        end
                     end
                  end
               end
               default: begin
                  pull <= 1'b0;
               end
            endcase
         end
      end
   end

   assign sda_oe    = pull;
   assign rd_addr_o = ptr;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_lvl,
   input logic sda_oe,
   input logic busy_i,
   input logic wr_en_o,
   input logic start_det,
   input logic stop_det,
   input logic in_tx
);
   AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe); // R1
   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe); // R1
   AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl); // R3
   AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && !in_tx) |-> !$past(busy_i)); // R4
   AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> sda_oe); // R6
   AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o); // R6
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .scl_lvl(scl_lvl),
   .sda_oe(sda_oe),
   .busy_i(busy_i),
   .wr_en_o(wr_en_o),
   .start_det(start_det),
   .stop_det(stop_det),
   .in_tx(in_tx)
);

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;
   localparam int Q = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic        busy = 1'b0;
   logic        sda_oe;
   logic        wr_en;
   logic [10:0] wr_addr;
   logic [7:0]  wr_data;
   logic [10:0] rd_addr;
   logic [7:0]  rd_data;
   logic        sda_line;
   logic [7:0]  mem [2048];
   int          checks = 0;
   int          failures = 0;
   int          wr_cnt = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;
   assign rd_data  = mem[rd_addr];

   twi_mem_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
      .busy_i(busy), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .rd_addr_o(rd_addr), .rd_data_i(rd_data)
   );

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7) ^ (a >> 3) ^ 8'h5C);
   endfunction

   always @(posedge clk) if (wr_en) begin
      mem[wr_addr] <= wr_data;
      wr_cnt <= wr_cnt + 1;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl = 1'b1; wq();
      acked = (sda_line == 1'b0);
      wq(); scl = 1'b0; wq();
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         wq(); scl = 1'b1; wq();
         b = {b[6:0], sda_line};
         wq(); scl = 1'b0;
      end
      sda_m = give_ack ? 1'b0 : 1'b1;
      wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
      sda_m = 1'b1;
   endtask

   task automatic t_reset();
      chk("R11 sda_oe after reset", sda_oe, 0);
      chk("R11 wr_en after reset", wr_en, 0);
   endtask

   task automatic t_byte_write();
      bit a;
      int n0 = wr_cnt;
      bus_start();
      send_byte(8'hA6, a); chk("R2 matching control acked", a, 1);
      chk("R3 released after ack", sda_oe, 0);
      send_byte(8'h45, a); chk("R5 word address acked", a, 1);
      send_byte(8'h5A, a); chk("R6 data acked", a, 1);
      bus_stop();
      chk("R5 R6 byte at 345h", mem[11'h345], 8'h5A);
      chk("R6 one strobe", wr_cnt - n0, 1);
   endtask

   task automatic t_reads();
      bit a;
      logic [7:0] d;
      int n0 = wr_cnt;
      bus_start(); send_byte(8'hA7, a);
      recv_byte(1'b0, d); bus_stop();
      chk("R9 current read after write to 345h", d, pat(11'h346));
      bus_start(); send_byte(8'hA4, a); send_byte(8'h35, a);
      bus_start(); send_byte(8'hA5, a); chk("R7 read control after repeated start", a, 1);
      recv_byte(1'b0, d); bus_stop();
      chk("R7 R8 random read 235h", d, pat(11'h235));
      chk("R7 no write strobe", wr_cnt - n0, 0);
      bus_start(); send_byte(8'hA5, a);
      recv_byte(1'b0, d); bus_stop();
      chk("R9 current read 236h", d, pat(11'h236));
   endtask

   task automatic t_seq_wrap();
      bit a;
      logic [7:0] d;
      bus_start(); send_byte(8'hAE, a); send_byte(8'hFE, a);
      bus_start(); send_byte(8'hAF, a);
      recv_byte(1'b1, d); chk("R8 seq 7FEh", d, pat(11'h7FE));
      recv_byte(1'b1, d); chk("R8 R10 seq 7FFh", d, pat(11'h7FF));
      recv_byte(1'b1, d); chk("R8 wrap to 000h", d, pat(0));
      recv_byte(1'b0, d); chk("R10 seq 001h", d, pat(1));
      for (int i = 0; i < 3; i++) begin
         wq(); scl = 1'b1; wq();
         chk("R10 released after nack", sda_line, 1);
         wq(); scl = 1'b0; wq();
      end
      bus_stop();
   endtask

   task automatic t_bad_code();
      bit a;
      int n0 = wr_cnt;
      bus_start();
      send_byte(8'hB6, a); chk("R2 wrong code nacked", a, 0);
      send_byte(8'h10, a); chk("R2 later byte ignored", a, 0);
      send_byte(8'h99, a); chk("R2 data ignored", a, 0);
      bus_stop();
      chk("R2 no write", wr_cnt - n0, 0);
      scl = 1'b0; wq();
      send_byte(8'hA0, a); chk("R1 byte after stop ignored", a, 0);
      bus_stop();
   endtask

   task automatic t_busy();
      bit a;
      int n0;
      busy = 1'b1;
      bus_start(); send_byte(8'hA0, a); chk("R4 control nacked while busy", a, 0);
      bus_stop();
      busy = 1'b0;
      bus_start(); send_byte(8'hA0, a); chk("R4 poll acked when idle", a, 1);
      bus_stop();
      n0 = wr_cnt;
      bus_start(); send_byte(8'hA2, a); send_byte(8'h20, a);
      busy = 1'b1;
      send_byte(8'h77, a); chk("R4 data nacked while busy", a, 0);
      bus_stop();
      busy = 1'b0;
      chk("R4 no write while busy", wr_cnt - n0, 0);
      chk("R4 byte 120h kept", mem[11'h120], pat(11'h120));
   endtask

   task automatic t_page_wrap();
      bit a;
      bus_start(); send_byte(8'hA2, a); send_byte(8'h0E, a);
      send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
      chk("R6 third data acked", a, 1);
      bus_stop();
      chk("R6 byte 10Eh", mem[11'h10E], 8'h11);
      chk("R6 byte 10Fh", mem[11'h10F], 8'h22);
      chk("R6 page wrap to 100h", mem[11'h100], 8'h33);
      chk("R6 next page untouched", mem[11'h110], pat(11'h110));
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      for (int i = 0; i < 2048; i++) mem[i] = pat(i);
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_byte_write();
      t_reads();
      t_seq_wrap();
      t_bad_code();
      t_busy();
      t_page_wrap();
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         report();
         $finish;
      end
   end
endmodule